// File: doc/BRIEF.md
# Gated-Version System Control Register Bank

This block is a small register bank behind a 32-bit APB-style slave port. It decodes a 1 KiB address window and implements three word registers. The first is a general control word that comes out of reset with a fixed value. The second is a chip-identity word that stays hidden until software sets an unlock bit inside it. The third is a scratch word that software may use freely. All other words in the window read as zero and ignore writes.

Only complete 32-bit accesses are accepted, meaning all four byte strobes must be set. Any access to an unmapped word, and any write with a partial strobe, is refused: it changes nothing and raises a one-cycle error pulse. Read data is registered and appears in the cycle after the access phase. A write to the identity word is visible to a read in the very next transaction.

Top module: `gvr_regbank`

## Requirements
- R1: After reset the control word (byte offset 0x04) reads 0x0000_1300, the scratch word (offset 0xBC) reads 0, and the identity word (offset 0x24) reads 0 because it starts locked.
- R2: The control word and the scratch word are read/write across all 32 bits. A full-strobe write is returned unchanged by a later read.
- R3: In the identity word, only bit 15 (the unlock bit) can be written. Every other written bit is discarded.
- R4: While the unlock bit is set, a read of offset 0x24 returns 0x1701 in bits 31:16, bit 15 set, and every other bit 0, giving 0x1701_8000. While the unlock bit is clear, the read returns 0.
- R5: Reads of any word offset other than 0x04, 0x24 and 0xBC return 0. Writes to those offsets change no register.
- R6: A write whose byte strobe is not 4'b1111 changes no register.
- R7: The error output is high for exactly the one cycle after the access phase of any access to an unmapped offset, and of any write with a partial strobe. It is low otherwise.
- R8: Read data is valid in the cycle after the access phase (psel & penable). A read that directly follows a write to the identity word already sees the new unlock state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 10 | Byte address inside the window |
| pwdata | input | 32 | Write data |
| pstrb | input | 4 | Byte strobes; must be all ones |
| prdata | output | 32 | Registered read data |
| perr | output | 1 | One-cycle error pulse |

## Verification
A wrong stored value shows at prdata only when that word is read back. The bench therefore reads every register after each write and after each refused access, and it sees the damage one cycle after that read. A lock bit that is stuck, or that leaks into other bits, changes the identity readback immediately, so reads are made both before and after unlock and relock writes. A decode fault in the error logic shows on perr in the cycle right after the access.

// File: rtl/gvr_pkg.sv
package gvr_pkg;
   localparam int unsigned DW = 32;
   localparam int unsigned AW = 10;
   localparam int unsigned WORD_AW = AW - 2;
   typedef enum logic [1:0] {SEL_NONE, SEL_CTRL, SEL_IDENT, SEL_SCRATCH} sel_e;
endpackage

// File: rtl/gvr_decode.sv
module gvr_decode
   import gvr_pkg::*;
#(
   parameter logic [WORD_AW-1:0] CTRL_WORD    = 8'h01,
   parameter logic [WORD_AW-1:0] IDENT_WORD   = 8'h09,
   parameter logic [WORD_AW-1:0] SCRATCH_WORD = 8'h2F
) (
   input  logic [AW-1:0] addr,
   output sel_e          sel
);
   initial begin
      if (CTRL_WORD == IDENT_WORD || CTRL_WORD == SCRATCH_WORD || IDENT_WORD == SCRATCH_WORD)
         $error("gvr_decode: register offsets collide");
   end
   logic [WORD_AW-1:0] word;
   assign word = addr[AW-1:2];
   always_comb begin
      if (word == CTRL_WORD)         sel = SEL_CTRL;
      else if (word == IDENT_WORD)   sel = SEL_IDENT;
      else if (word == SCRATCH_WORD) sel = SEL_SCRATCH;
      else                           sel = SEL_NONE;
   end
endmodule

// File: rtl/gvr_rwreg.sv
module gvr_rwreg #(
   parameter int unsigned W = 32,
   parameter logic [W-1:0] RST_VAL = '0,
   parameter logic [W-1:0] WMASK = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   initial begin
      if (W < 1) $error("gvr_rwreg: width must be positive");
   end
   for (genvar i = 0; i < W; i++) begin : g_bit
      if (WMASK[i]) begin : g_rw
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n)  q[i] <= RST_VAL[i];
            else if (we) q[i] <= wdata[i];
      end else begin : g_ro
         assign q[i] = RST_VAL[i];
      end
   end
endmodule

// File: rtl/gvr_regbank.sv
module gvr_regbank
   import gvr_pkg::*;
#(
   parameter logic [DW-1:0] CTRL_RESET   = 32'h0000_1300,
   parameter logic [15:0]   CHIP_CODE    = 16'h1701,
   parameter int unsigned   UNLOCK_BIT   = 15,
   parameter logic [AW-1:0] CTRL_OFS     = 10'h004,
   parameter logic [AW-1:0] IDENT_OFS    = 10'h024,
   parameter logic [AW-1:0] SCRATCH_OFS  = 10'h0BC
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          psel,
   input  logic          penable,
   input  logic          pwrite,
   input  logic [AW-1:0] paddr,
   input  logic [DW-1:0] pwdata,
   input  logic [3:0]    pstrb,
   output logic [DW-1:0] prdata,
   output logic          perr
);
   localparam logic [DW-1:0] UNLOCK_MASK = DW'(1) << UNLOCK_BIT;
   localparam logic [DW-1:0] ID_VALUE = {CHIP_CODE, 16'h0} | UNLOCK_MASK;

   initial begin
      if (UNLOCK_BIT > 15) $error("gvr_regbank: unlock bit must sit below the code field");
      if (CTRL_OFS[1:0] != 2'b00 || IDENT_OFS[1:0] != 2'b00 || SCRATCH_OFS[1:0] != 2'b00)
         $error("gvr_regbank: offsets must be word aligned");
   end

   sel_e sel;
   gvr_decode #(
      .CTRL_WORD(CTRL_OFS[AW-1:2]), .IDENT_WORD(IDENT_OFS[AW-1:2]),
      .SCRATCH_WORD(SCRATCH_OFS[AW-1:2])
   ) u_dec (.addr(paddr), .sel(sel));

   logic access, full, wr_ok, bad;
   assign access = psel & penable;
   assign full   = (pstrb == 4'b1111);
   assign wr_ok  = access & pwrite & full;
   assign bad    = access & ((sel == SEL_NONE) | (pwrite & ~full));

   logic [DW-1:0] ctrl_q, ident_q, scratch_q;
   gvr_rwreg #(.W(DW), .RST_VAL(CTRL_RESET), .WMASK('1)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .we(wr_ok && sel == SEL_CTRL),
      .wdata(pwdata), .q(ctrl_q));
   gvr_rwreg #(.W(DW), .RST_VAL('0), .WMASK(UNLOCK_MASK)) u_ident (
      .clk(clk), .rst_n(rst_n), .we(wr_ok && sel == SEL_IDENT),
      .wdata(pwdata), .q(ident_q));
   gvr_rwreg #(.W(DW), .RST_VAL('0), .WMASK('1)) u_scratch (
      .clk(clk), .rst_n(rst_n), .we(wr_ok && sel == SEL_SCRATCH),
      .wdata(pwdata), .q(scratch_q));

   logic [DW-1:0] rd_mux;
   always_comb begin
      unique case (sel)
         SEL_CTRL:    rd_mux = ctrl_q;
         SEL_IDENT:   rd_mux = (ident_q[UNLOCK_BIT]) ? ID_VALUE : '0;
         SEL_SCRATCH: rd_mux = scratch_q;
         default:     rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prdata <= '0;
         perr   <= 1'b0;
      end else begin
         perr <= bad;
         if (access && !pwrite) prdata <= rd_mux;
      end
   end

   // Identity register keeps only the unlock bit (R3)
   p_ident_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ident_q & ~UNLOCK_MASK) == '0);
   // Refused writes leave the scratch word unchanged (R6)
   p_partial_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (access && pwrite && !full) |=> $stable(scratch_q) && $stable(ctrl_q));
   // Error pulses follow unmapped accesses (R7)
   p_err_unmapped_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (access && sel == SEL_NONE) |=> perr);
   // Error never raised without an access in the previous cycle (R7)
   p_err_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !access |=> !perr);
   // Unmapped reads give zero (R5)
   p_unmapped_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (access && !pwrite && sel == SEL_NONE) |=> prdata == '0);
   // Identity read is either zero or the full value (R4)
   p_ident_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (access && !pwrite && sel == SEL_IDENT) |=> (prdata == '0 || prdata == ID_VALUE));
endmodule

// File: tb/gvr_regbank_test.sv
module gvr_regbank_test;
   localparam time CLK_PERIOD = 10ns;
   logic clk = 0, rst_n = 0;
   logic psel = 0, penable = 0, pwrite = 0;
   logic [9:0] paddr = '0;
   logic [31:0] pwdata = '0;
   logic [3:0] pstrb = '0;
   logic [31:0] prdata;
   logic perr;
   int checks = 0, errors = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gvr_regbank uut (.clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
      .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb),
      .prdata(prdata), .perr(perr));

   // vector: write?, addr, data, strb, expected read data (reads only), expected perr
   typedef struct packed {
      logic        wr;
      logic [9:0]  addr;
      logic [31:0] data;
      logic [3:0]  strb;
      logic [31:0] exp;
      logic        experr;
   } vec_t;
   localparam int NV = 16;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 10'h004, 32'h0, 4'hF, 32'h0000_1300, 1'b0},  // R1 ctrl reset
      '{1'b0, 10'h0BC, 32'h0, 4'hF, 32'h0,         1'b0},  // R1 scratch reset
      '{1'b0, 10'h024, 32'h0, 4'hF, 32'h0,         1'b0},  // R1 locked ident
      '{1'b1, 10'h004, 32'hDEAD_BEEF, 4'hF, 32'h0, 1'b0},  // R2
      '{1'b0, 10'h004, 32'h0, 4'hF, 32'hDEAD_BEEF, 1'b0},  // R2
      '{1'b1, 10'h0BC, 32'hA5A5_5A5A, 4'hF, 32'h0, 1'b0},  // R2
      '{1'b0, 10'h0BC, 32'h0, 4'hF, 32'hA5A5_5A5A, 1'b0},  // R2
      '{1'b1, 10'h024, 32'hFFFF_7FFF, 4'hF, 32'h0, 1'b0},  // R3 all but unlock
      '{1'b0, 10'h024, 32'h0, 4'hF, 32'h0,         1'b0},  // R3 still locked
      '{1'b1, 10'h024, 32'h0000_8000, 4'hF, 32'h0, 1'b0},  // R4 unlock
      '{1'b0, 10'h024, 32'h0, 4'hF, 32'h1701_8000, 1'b0},  // R4/R8 next txn
      '{1'b1, 10'h0BC, 32'h1234_5678, 4'h3, 32'h0, 1'b1},  // R6 partial write
      '{1'b0, 10'h0BC, 32'h0, 4'hF, 32'hA5A5_5A5A, 1'b0},  // R6 unchanged
      '{1'b1, 10'h008, 32'hFFFF_FFFF, 4'hF, 32'h0, 1'b1},  // R5 unmapped write
      '{1'b0, 10'h008, 32'h0, 4'hF, 32'h0,         1'b1},  // R5/R7 unmapped read
      '{1'b1, 10'h024, 32'h0000_0000, 4'hF, 32'h0, 1'b0}   // R4 relock
   };

   task automatic xfer(input logic wr, input logic [9:0] a, input logic [31:0] d,
                       input logic [3:0] s);
      @(negedge clk);
      psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = d; pstrb = s;
      @(negedge clk);
      penable = 1;
      @(negedge clk);   // one edge after access phase: outputs registered
      psel = 0; penable = 0;
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   initial begin
      #(CLK_PERIOD*5000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 prdata reset", prdata, 32'h0);
      check("R7 perr reset", {31'b0, perr}, 32'h0);
      rst_n = 1;
      for (int i = 0; i < NV; i++) begin
         xfer(VEC[i].wr, VEC[i].addr, VEC[i].data, VEC[i].strb);
         if (!VEC[i].wr) check($sformatf("R2/R4/R5 vec%0d prdata", i), prdata, VEC[i].exp);
         check($sformatf("R7 vec%0d perr", i), {31'b0, perr}, {31'b0, VEC[i].experr});
      end
      // R4 relocked reads zero
      xfer(0, 10'h024, 0, 4'hF);
      check("R4 relocked", prdata, 32'h0);
      // R7 perr is a single-cycle pulse
      xfer(0, 10'h3FC, 0, 4'hF);
      check("R7 pulse high", {31'b0, perr}, 32'h1);
      @(negedge clk);
      check("R7 pulse drops", {31'b0, perr}, 32'h0);
      // R5 unmapped write did not reach ctrl or scratch
      xfer(1, 10'h0C0, 32'h0BAD_0BAD, 4'hF);
      xfer(0, 10'h004, 0, 4'hF);
      check("R5 ctrl intact", prdata, 32'hDEAD_BEEF);
      // R6 partial write to ctrl refused
      xfer(1, 10'h004, 32'h0, 4'hE);
      xfer(0, 10'h004, 0, 4'hF);
      check("R6 ctrl intact", prdata, 32'hDEAD_BEEF);
      // R8 back-to-back unlock then read
      xfer(1, 10'h024, 32'hFFFF_FFFF, 4'hF);
      xfer(0, 10'h024, 0, 4'hF);
      check("R8 immediate unlock", prdata, 32'h1701_8000);
      // R1 reset again
      @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
      xfer(0, 10'h004, 0, 4'hF);
      check("R1 ctrl after reset", prdata, 32'h0000_1300);
      xfer(0, 10'h024, 0, 4'hF);
      check("R1 ident locked after reset", prdata, 32'h0);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule